// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing for one display output. A mode is given on plain configuration inputs: active width, front porch, sync width and back porch for each axis, two polarity flags, an interlace flag and a channel select. A one-cycle `apply_i` pulse takes the mode. From that point the block runs a pixel counter and a line counter. It drives hsync, vsync, data-enable and a field flag, and it shows the running counters.

Until the first mode is applied, the output-enable is low, the sync and data-enable pins are parked at 0 and the counters are held at 0. The block also reports two derived values to the rest of the chip: the vertical total in the form the selected channel expects, and a saturating start-of-frame delay computed from the vertical blanking. If a mode is applied while a raster is running, it is held back and loaded at the next frame (or field) boundary, so the running frame is never torn.

Top module: `raster_timer`

## Requirements
- R1: A line lasts h_act+h_fp+h_sw+h_bp cycles. `px_o` counts 0 up to that length minus 1 and then wraps to 0. The internal back-porch offset is h_sw+h_bp.
- R2: A field has fact+v_fp+v_sw+v_bp lines. Here fact is v_act in progressive mode and floor(v_act/2) in interlaced mode. `ln_o` steps when `px_o` wraps and returns to 0 after the last line.
- R3: `vtot_o` reports v_act+v_fp+v_sw+v_bp. The value is doubled (half-line units) only when `chan_i`=1 (secondary channel) and interlace is off.
- R4: `sdly_o` starts from v_fp+v_sw+v_bp. The value is halved (floor) when interlaced, then reduced by 2 when `chan_i`=1, then limited to the range 0..30.
- R5: hsync is asserted while `px_o` < h_sw, and vsync while `ln_o` < v_sw. A pin idles high and pulses low when its low flag is 1. It idles low and pulses high when the flag is 0.
- R6: `de_o` is 1 exactly when h_sw+h_bp <= `px_o` < h_sw+h_bp+h_act and v_sw+v_bp <= `ln_o` < v_sw+v_bp+fact.
- R7: After reset, and until a mode is applied, `out_en_o`, `hsync_o`, `vsync_o`, `de_o`, `px_o`, `ln_o`, `vtot_o` and `sdly_o` are all 0. An apply pulse while idle takes effect at the next clock edge: `out_en_o`=1, with pixel 0 and line 0 visible in the following cycle.
- R8: `field_o` is 0 in the first field after a mode is loaded. In interlaced mode it toggles on every vertical wrap. It stays 0 in progressive mode.
- R9: In interlaced mode, data-enable covers only floor(v_act/2) lines per field.
- R10: An apply pulse sampled while running, before the last pixel of the frame, leaves the current frame unchanged. The new mode starts at pixel 0, line 0 right after that frame's last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apply_i | input | 1 | One-cycle pulse taking the mode on the configuration inputs |
| h_act_i | input | HW | Active pixels per line |
| h_fp_i | input | HW | Horizontal front porch |
| h_sw_i | input | HW | Horizontal sync width |
| h_bp_i | input | HW | Horizontal back porch |
| v_act_i | input | VW | Active lines per frame |
| v_fp_i | input | VW | Vertical front porch |
| v_sw_i | input | VW | Vertical sync width |
| v_bp_i | input | VW | Vertical back porch |
| hs_low_i | input | 1 | Horizontal sync active-low when 1 |
| vs_low_i | input | 1 | Vertical sync active-low when 1 |
| ilace_i | input | 1 | Interlaced mode when 1 |
| chan_i | input | 1 | 0 primary channel, 1 secondary channel |
| out_en_o | output | 1 | Output drivers enabled (0 means tristated) |
| hsync_o | output | 1 | Horizontal sync pin value |
| vsync_o | output | 1 | Vertical sync pin value |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Field indicator |
| px_o | output | HW | Pixel counter |
| ln_o | output | VW | Line counter |
| vtot_o | output | VW+1 | Channel-form vertical total |
| sdly_o | output | 5 | Start-of-frame delay |

## Verification
The bench runs three modes back to back. The second and third modes are applied in the middle of a frame, so the seam is checked. A design that swapped modes at once would show a torn frame with the counters jumping. The delay corners are a sum that goes negative after the channel reduction, which a design without a floor would wrap to a large value, and a long blanking that must clip at 30. The vertical total is checked both doubled and not doubled. Field toggling and half-height active regions are checked in interlaced mode. Inverted polarity is checked so that a design which ignored the low flags would show sync pulses of the wrong sense.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int DLY_W   = 5;
    localparam int DLY_MAX = 30;
    localparam int DLY_CHAN_ADJ = 2;

    typedef enum logic {
        CHAN_PRI = 1'b0,
        CHAN_SEC = 1'b1
    } chan_e;
endpackage

// File: rtl/raster_derive.sv
module raster_derive
    import raster_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic [HW-1:0]    h_act,
    input  logic [HW-1:0]    h_fp,
    input  logic [HW-1:0]    h_sw,
    input  logic [HW-1:0]    h_bp,
    input  logic [VW-1:0]    v_act,
    input  logic [VW-1:0]    v_fp,
    input  logic [VW-1:0]    v_sw,
    input  logic [VW-1:0]    v_bp,
    input  logic             ilace,
    input  logic             chan,
    output logic [HW-1:0]    h_off,
    output logic [HW-1:0]    h_tot,
    output logic [VW-1:0]    v_off,
    output logic [VW-1:0]    fld_act,
    output logic [VW-1:0]    fld_lines,
    output logic [VW:0]      v_tot_reg,
    output logic [DLY_W-1:0] sdly
);
    localparam int BW = VW + 2;
    localparam int SW = VW + 3;
    localparam logic signed [SW-1:0] MAX_S = SW'(DLY_MAX);
    localparam logic signed [SW-1:0] ADJ_S = SW'(DLY_CHAN_ADJ);

    logic [VW-1:0] v_frame;
    logic [BW-1:0] blank;
    logic [BW-1:0] blank_f;
    logic signed [SW-1:0] adj;
    logic sec;

    always_comb begin
        sec       = (chan == CHAN_SEC);
        h_off     = h_sw + h_bp;
        h_tot     = h_act + h_fp + h_off;
        v_off     = v_sw + v_bp;
        v_frame   = v_act + v_fp + v_off;
        fld_act   = ilace ? (v_act >> 1) : v_act;
        fld_lines = fld_act + v_fp + v_off;
        v_tot_reg = (sec && !ilace) ? {v_frame, 1'b0} : {1'b0, v_frame};

        blank   = {2'b00, v_fp} + {2'b00, v_sw} + {2'b00, v_bp};
        blank_f = ilace ? (blank >> 1) : blank;
        adj     = $signed({1'b0, blank_f}) - (sec ? ADJ_S : '0);
        if (adj < 0)
            sdly = '0;
        else if (adj > MAX_S)
            sdly = DLY_W'(DLY_MAX);
        else
            sdly = adj[DLY_W-1:0];
    end
endmodule

// File: rtl/raster_scan.sv
module raster_scan #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic          ilace,
    input  logic [HW-1:0] h_tot,
    input  logic [VW-1:0] fld_lines,
    output logic [HW-1:0] px,
    output logic [VW-1:0] ln,
    output logic          fld,
    output logic          frame_end
);
    typedef struct packed {
        logic [HW-1:0] px;
        logic [VW-1:0] ln;
        logic          fld;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  line_end;

    always_comb begin
        scan_d    = scan_q;
        line_end  = run && (scan_q.px == h_tot - HW'(1));
        frame_end = line_end && (scan_q.ln == fld_lines - VW'(1));
        if (load) begin
            scan_d = '0;
        end else if (run) begin
            if (line_end) begin
                scan_d.px = '0;
                if (frame_end) begin
                    scan_d.ln  = '0;
                    scan_d.fld = ilace ? ~scan_q.fld : 1'b0;
                end else begin
                    scan_d.ln = scan_q.ln + VW'(1);
                end
            end else begin
                scan_d.px = scan_q.px + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scan_q <= '0;
        else
            scan_q <= scan_d;
    end

    assign px  = scan_q.px;
    assign ln  = scan_q.ln;
    assign fld = scan_q.fld;
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply_i,
    input  logic [HW-1:0]    h_act_i,
    input  logic [HW-1:0]    h_fp_i,
    input  logic [HW-1:0]    h_sw_i,
    input  logic [HW-1:0]    h_bp_i,
    input  logic [VW-1:0]    v_act_i,
    input  logic [VW-1:0]    v_fp_i,
    input  logic [VW-1:0]    v_sw_i,
    input  logic [VW-1:0]    v_bp_i,
    input  logic             hs_low_i,
    input  logic             vs_low_i,
    input  logic             ilace_i,
    input  logic             chan_i,
    output logic             out_en_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             field_o,
    output logic [HW-1:0]    px_o,
    output logic [VW-1:0]    ln_o,
    output logic [VW:0]      vtot_o,
    output logic [DLY_W-1:0] sdly_o
);
    typedef struct packed {
        logic [HW-1:0] h_act;
        logic [HW-1:0] h_fp;
        logic [HW-1:0] h_sw;
        logic [HW-1:0] h_bp;
        logic [VW-1:0] v_act;
        logic [VW-1:0] v_fp;
        logic [VW-1:0] v_sw;
        logic [VW-1:0] v_bp;
        logic          hs_low;
        logic          vs_low;
        logic          ilace;
        logic          chan;
    } mode_t;

    typedef struct packed {
        mode_t mode;
        mode_t held;
        logic  held_vld;
        logic  run;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    mode_t mode_in;
    logic  load;
    logic  frame_end;
    logic  ilace_act;
    logic [$bits(mode_t)-1:0] cfg_bits;

    logic [HW-1:0] h_off, h_tot;
    logic [VW-1:0] v_off, fld_act, fld_lines;
    logic [VW:0]   v_tot_reg;
    logic [DLY_W-1:0] sdly;
    logic [HW-1:0] px;
    logic [VW-1:0] ln;
    logic          fld;
    logic          hs_act, vs_act, h_in, v_in;

    always_comb begin
        mode_in = '{h_act: h_act_i, h_fp: h_fp_i, h_sw: h_sw_i, h_bp: h_bp_i,
                    v_act: v_act_i, v_fp: v_fp_i, v_sw: v_sw_i, v_bp: v_bp_i,
                    hs_low: hs_low_i, vs_low: vs_low_i,
                    ilace: ilace_i, chan: chan_i};
    end

    // Mode staging: immediate load when idle, boundary load when running.
    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        if (!ctl_q.run) begin
            if (apply_i) begin
                ctl_d.mode = mode_in;
                ctl_d.run  = 1'b1;
                load       = 1'b1;
            end
        end else begin
            if (frame_end && ctl_q.held_vld) begin
                ctl_d.mode     = ctl_q.held;
                ctl_d.held_vld = 1'b0;
                load           = 1'b1;
            end
            if (apply_i) begin
                ctl_d.held     = mode_in;
                ctl_d.held_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign cfg_bits  = ctl_q.mode;
    assign ilace_act = ctl_q.mode.ilace;

    raster_derive #(.HW(HW), .VW(VW)) u_derive (
        .h_act     (ctl_q.mode.h_act),
        .h_fp      (ctl_q.mode.h_fp),
        .h_sw      (ctl_q.mode.h_sw),
        .h_bp      (ctl_q.mode.h_bp),
        .v_act     (ctl_q.mode.v_act),
        .v_fp      (ctl_q.mode.v_fp),
        .v_sw      (ctl_q.mode.v_sw),
        .v_bp      (ctl_q.mode.v_bp),
        .ilace     (ctl_q.mode.ilace),
        .chan      (ctl_q.mode.chan),
        .h_off     (h_off),
        .h_tot     (h_tot),
        .v_off     (v_off),
        .fld_act   (fld_act),
        .fld_lines (fld_lines),
        .v_tot_reg (v_tot_reg),
        .sdly      (sdly)
    );

    raster_scan #(.HW(HW), .VW(VW)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.run),
        .load      (load),
        .ilace     (ctl_q.mode.ilace),
        .h_tot     (h_tot),
        .fld_lines (fld_lines),
        .px        (px),
        .ln        (ln),
        .fld       (fld),
        .frame_end (frame_end)
    );

    always_comb begin
        hs_act   = px < ctl_q.mode.h_sw;
        vs_act   = ln < ctl_q.mode.v_sw;
        h_in     = (px >= h_off) && (px < h_off + ctl_q.mode.h_act);
        v_in     = (ln >= v_off) && (ln < v_off + fld_act);
        out_en_o = ctl_q.run;
        hsync_o  = ctl_q.run && (hs_act ^ ctl_q.mode.hs_low);
        vsync_o  = ctl_q.run && (vs_act ^ ctl_q.mode.vs_low);
        de_o     = ctl_q.run && h_in && v_in;
        field_o  = fld;
        px_o     = px;
        ln_o     = ln;
        vtot_o   = v_tot_reg;
        sdly_o   = sdly;
    end
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe,
    input logic          hs,
    input logic          vs,
    input logic          de,
    input logic          field,
    input logic [HW-1:0] px,
    input logic [VW-1:0] ln,
    input logic [4:0]    sdly,
    input logic          ilace_q,
    input logic          frame_end,
    input logic [CW-1:0] cfg_bits
);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!hs && !vs && !de && px == '0 && ln == '0));

    assert_px_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && px != '0) |-> (px == $past(px) + {{(HW-1){1'b0}}, 1'b1}));

    assert_de_needs_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> oe);

    assert_prog_field_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !ilace_q) |-> !field);

    assert_delay_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sdly <= 5'd30);

    assert_mode_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !frame_end) |=> $stable(cfg_bits));
endmodule

bind raster_timer raster_timer_chk #(.HW(HW), .VW(VW), .CW($bits(cfg_bits))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe        (out_en_o),
    .hs        (hsync_o),
    .vs        (vsync_o),
    .de        (de_o),
    .field     (field_o),
    .px        (px_o),
    .ln        (ln_o),
    .sdly      (sdly_o),
    .ilace_q   (ilace_act),
    .frame_end (frame_end),
    .cfg_bits  (cfg_bits)
);

// File: tb/sim_raster_timer.sv
module sim_raster_timer;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 12;
    localparam int VW = 11;

    typedef struct packed {
        logic [HW-1:0] px;
        logic [VW-1:0] ln;
        logic          hs;
        logic          vs;
        logic          de;
        logic          fld;
        logic          oe;
        logic [VW:0]   vtot;
        logic [4:0]    dly;
        logic          ilc;
        logic          seam;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic apply_i;
    logic [HW-1:0] h_act_i, h_fp_i, h_sw_i, h_bp_i;
    logic [VW-1:0] v_act_i, v_fp_i, v_sw_i, v_bp_i;
    logic hs_low_i, vs_low_i, ilace_i, chan_i;
    logic out_en_o, hsync_o, vsync_o, de_o, field_o;
    logic [HW-1:0] px_o;
    logic [VW-1:0] ln_o;
    logic [VW:0]   vtot_o;
    logic [4:0]    sdly_o;

    exp_t q[$];
    exp_t cur;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timer #(.HW(HW), .VW(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .apply_i(apply_i),
        .h_act_i(h_act_i), .h_fp_i(h_fp_i), .h_sw_i(h_sw_i), .h_bp_i(h_bp_i),
        .v_act_i(v_act_i), .v_fp_i(v_fp_i), .v_sw_i(v_sw_i), .v_bp_i(v_bp_i),
        .hs_low_i(hs_low_i), .vs_low_i(vs_low_i), .ilace_i(ilace_i), .chan_i(chan_i),
        .out_en_o(out_en_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .field_o(field_o), .px_o(px_o), .ln_o(ln_o), .vtot_o(vtot_o), .sdly_o(sdly_o)
    );

    task automatic chk(input int act, input int expv, input string req);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Monitor: compare one expected item per cycle, away from the clock edge.
    always @(negedge clk) begin
        if (!done && q.size() > 0) begin
            cur = q.pop_front();
            chk(int'(px_o), int'(cur.px), "R1 pixel counter");
            chk(int'(ln_o), int'(cur.ln), "R2 line counter");
            chk(int'(hsync_o), int'(cur.hs), "R5 hsync pin");
            chk(int'(vsync_o), int'(cur.vs), "R5 vsync pin");
            chk(int'(de_o), int'(cur.de), cur.ilc ? "R9 field data enable" : "R6 data enable");
            chk(int'(field_o), int'(cur.fld), "R8 field flag");
            chk(int'(out_en_o), int'(cur.oe), "R7 output enable");
            chk(int'(vtot_o), int'(cur.vtot), "R3 vertical total");
            chk(int'(sdly_o), int'(cur.dly), "R4 start delay");
            if (cur.seam)
                chk(int'(px_o == '0 && ln_o == '0), 1, "R10 mode starts at boundary");
        end
    end

    task automatic set_mode(input int ha, input int hf, input int hs, input int hb,
                            input int va, input int vf, input int vs, input int vb,
                            input bit hl, input bit vl, input bit il, input bit ch);
        h_act_i = HW'(ha); h_fp_i = HW'(hf); h_sw_i = HW'(hs); h_bp_i = HW'(hb);
        v_act_i = VW'(va); v_fp_i = VW'(vf); v_sw_i = VW'(vs); v_bp_i = VW'(vb);
        hs_low_i = hl; vs_low_i = vl; ilace_i = il; chan_i = ch;
        apply_i = 1'b1;
        @(posedge clk); #1;
        apply_i = 1'b0;
    endtask

    // Driver: push the expected raster of nfr frames/fields of a mode.
    task automatic push_mode(input int ha, input int hf, input int hs, input int hb,
                             input int va, input int vf, input int vs, input int vb,
                             input bit hl, input bit vl, input bit il, input bit ch,
                             input int nfr);
        int htot = ha + hf + hs + hb;
        int hoff = hs + hb;
        int fact = il ? va / 2 : va;
        int voff = vs + vb;
        int lines = fact + vf + voff;
        int vt = va + vf + voff;
        int d = vf + vs + vb;
        exp_t e;
        if (ch && !il) vt = vt * 2;
        if (il) d = d / 2;
        if (ch) d = d - 2;
        if (d < 0) d = 0;
        if (d > 30) d = 30;
        for (int f = 0; f < nfr; f++) begin
            for (int l = 0; l < lines; l++) begin
                for (int p = 0; p < htot; p++) begin
                    e.px   = HW'(p);
                    e.ln   = VW'(l);
                    e.hs   = (p < hs) ? ~hl : hl;
                    e.vs   = (l < vs) ? ~vl : vl;
                    e.de   = (p >= hoff) && (p < hoff + ha) && (l >= voff) && (l < voff + fact);
                    e.fld  = il ? f[0] : 1'b0;
                    e.oe   = 1'b1;
                    e.vtot = (VW+1)'(vt);
                    e.dly  = 5'(d);
                    e.ilc  = il;
                    e.seam = (f == 0 && l == 0 && p == 0);
                    q.push_back(e);
                end
            end
        end
    endtask

    task automatic wait_tail(input int lim);
        do begin
            @(posedge clk); #1;
        end while (q.size() > lim);
    endtask

    initial begin
        rst_n = 1'b0;
        apply_i = 1'b0;
        h_act_i = '0; h_fp_i = '0; h_sw_i = '0; h_bp_i = '0;
        v_act_i = '0; v_fp_i = '0; v_sw_i = '0; v_bp_i = '0;
        hs_low_i = 1'b0; vs_low_i = 1'b0; ilace_i = 1'b0; chan_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7: idle state before any mode, with config inputs changing.
        h_sw_i = 12'd3; v_sw_i = 11'd2; hs_low_i = 1'b1; vs_low_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(int'(out_en_o), 0, "R7 idle output enable");
            chk(int'(hsync_o), 0, "R7 idle hsync");
            chk(int'(vsync_o), 0, "R7 idle vsync");
            chk(int'(de_o), 0, "R7 idle data enable");
            chk(int'(px_o) + int'(ln_o), 0, "R7 idle counters");
            chk(int'(vtot_o) + int'(sdly_o), 0, "R7 idle derived values");
        end
        @(posedge clk); #1;

        // Mode A: progressive, primary channel, active-high syncs.
        set_mode(4,1,1,2, 3,1,1,1, 0,0,0,0);
        push_mode(4,1,1,2, 3,1,1,1, 0,0,0,0, 2);

        // Mode B applied mid-frame: interlaced, secondary, active-low, delay floor.
        wait_tail(24);
        set_mode(4,1,1,2, 4,1,1,1, 1,1,1,1);
        push_mode(4,1,1,2, 4,1,1,1, 1,1,1,1, 3);

        // Mode C applied mid-field: progressive secondary, long blanking, delay cap.
        wait_tail(20);
        set_mode(4,1,1,2, 2,30,4,6, 0,1,0,1);
        push_mode(4,1,1,2, 2,30,4,6, 0,1,0,1, 1);

        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired, queue depth actual=%0d expected=0", q.size());
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule